// File: doc/BRIEF.md
# Salt-and-Pepper Pixel Restorer

This block repairs impulse noise in 8-bit grayscale imagery one pixel at a time. Each cycle it may accept a full 3x3 neighbourhood. If the middle sample is saturated (black or white), the block computes a replacement. If the middle sample is not saturated, the block returns it unchanged. The same block can be reused for each colour plane and for every frame of a video stream.

A replacement is the median of the window samples that are not saturated. If every sample in the window is saturated, the replacement is instead the rounded mean of the nine samples. The datapath is a fixed four-register pipeline. A valid flag travels with the data, and there is no backpressure. The surrounding line buffers supply the windows, and they decide what to do at image borders.

Top module: `snp_restorer`

## Requirements
- R1: A sample whose value is exactly 0 or exactly 255 counts as noise. Every value from 1 to 254 counts as clean.
- R2: When the centre sample is clean, `res_pixel` equals that centre value.
- R3: When the centre sample is noise and at least one window sample is clean, `res_pixel` is the median of the clean samples only. Saturated samples take no part in the ordering.
- R4: When the clean count is even, the median is the lower of the two middle values of the clean samples in ascending order.
- R5: When all nine samples are noise, `res_pixel` is round(255*c/9), where c is the number of samples equal to 255. For c = 0 through 9 this gives 0, 28, 57, 85, 113, 142, 170, 198, 227 and 255.
- R6: While `rst` is high at a rising edge, `res_valid` is low after that edge.
- R7: The result for a window appears on the fourth rising edge, counting the edge that samples `win_valid` high. `res_valid` is high for exactly that one cycle. Windows presented on consecutive cycles give results on consecutive cycles, in the same order.
- R8: Window element i occupies bits [8i+7:8i] of `win_pixels`, for i from 0 to 8. The rows are stored top to bottom and each row left to right, so element 4 is the centre sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| win_valid | input | 1 | The window on `win_pixels` is valid this cycle |
| win_pixels | input | 72 | Nine 8-bit samples; element 4 is the centre |
| res_valid | output | 1 | `res_pixel` holds a result this cycle |
| res_pixel | output | 8 | Restored (or passed-through) centre value |

## Verification
Because the pipeline has no stalls, one cycle can both accept a new window and deliver the result of a window taken three cycles earlier. The two windows may need different treatment, for example a pass-through arriving while a trimmed median or an all-noise mean is being delivered. The bench provokes this case by streaming its whole vector table on back-to-back cycles. It judges each delivered value against the vector issued four edges before, so any mixing of data between stages or any lost slot shows up as a value or order error. The bench also raises reset while windows are in flight and then checks that no stale result emerges.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [1:0] {
    PX_CLEAN = 2'd0,
    PX_LOW   = 2'd1,
    PX_HIGH  = 2'd2
  } px_class_e;

  function automatic px_class_e classify_px(input logic [15:0] v, input int w);
    logic [15:0] top;
    top = 16'((1 << w) - 1);
    if (v == 16'd0)      return PX_LOW;
    else if (v == top)   return PX_HIGH;
    else                 return PX_CLEAN;
  endfunction

endpackage

// File: rtl/snp_classify.sv
module snp_classify
  import snp_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int WIN   = 9,
  localparam int KEY_W = PIX_W + 1,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input  logic [WIN*PIX_W-1:0] pixels,
  output logic [WIN*KEY_W-1:0] keys,
  output logic [CNT_W-1:0]     clean_cnt,
  output logic [CNT_W-1:0]     high_cnt
);

  logic [WIN-1:0] is_clean;
  logic [WIN-1:0] is_high;

  for (genvar i = 0; i < WIN; i++) begin : g_px
    px_class_e cls;
    assign cls = classify_px(16'(pixels[i*PIX_W +: PIX_W]), PIX_W);
    assign is_clean[i] = (cls == PX_CLEAN);
    assign is_high[i]  = (cls == PX_HIGH);
    // noise keys carry the top bit so they sort above every clean sample
    assign keys[i*KEY_W +: KEY_W] = is_clean[i] ? {1'b0, pixels[i*PIX_W +: PIX_W]}
                                                : {KEY_W{1'b1}};
  end

  always_comb begin
    clean_cnt = '0;
    high_cnt  = '0;
    for (int i = 0; i < WIN; i++) begin
      clean_cnt = clean_cnt + CNT_W'(is_clean[i]);
      high_cnt  = high_cnt + CNT_W'(is_high[i]);
    end
  end

endmodule

// File: rtl/snp_sort_net.sv
module snp_sort_net #(
  parameter int KEY_W = 9,
  parameter int N     = 9
) (
  input  logic [N*KEY_W-1:0] keys_in,
  output logic [N*KEY_W-1:0] keys_out
);

  logic [N*KEY_W-1:0] st [N+1];

  assign st[0]    = keys_in;
  assign keys_out = st[N];

  // odd-even transposition: N stages sort N keys ascending
  for (genvar s = 0; s < N; s++) begin : g_stage
    for (genvar i = 0; i < N; i++) begin : g_lane
      if ((i % 2) == (s % 2) && (i + 1) < N) begin : g_cx
        logic [KEY_W-1:0] a, b;
        assign a = st[s][i*KEY_W +: KEY_W];
        assign b = st[s][(i+1)*KEY_W +: KEY_W];
        assign st[s+1][i*KEY_W +: KEY_W]     = (a <= b) ? a : b;
        assign st[s+1][(i+1)*KEY_W +: KEY_W] = (a <= b) ? b : a;
      end else if (!(i > 0 && ((i - 1) % 2) == (s % 2))) begin : g_pass
        assign st[s+1][i*KEY_W +: KEY_W] = st[s][i*KEY_W +: KEY_W];
      end
    end
  end

endmodule

// File: rtl/snp_fallback_mean.sv
module snp_fallback_mean #(
  parameter int PIX_W = 8,
  parameter int WIN   = 9,
  localparam int CNT_W = $clog2(WIN + 1),
  localparam int SUM_W = PIX_W + CNT_W + 1
) (
  input  logic [CNT_W-1:0] high_cnt,
  output logic [PIX_W-1:0] mean
);

  localparam logic [SUM_W-1:0] FULL = SUM_W'((1 << PIX_W) - 1);
  localparam logic [SUM_W-1:0] DIV  = SUM_W'(WIN);
  localparam logic [SUM_W-1:0] HALF = SUM_W'(WIN / 2);

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] quot;

  assign sum  = FULL * SUM_W'(high_cnt) + HALF;
  assign quot = sum / DIV;
  assign mean = quot[PIX_W-1:0];

endmodule

// File: rtl/snp_restorer.sv
module snp_restorer
  import snp_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int WIN   = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 win_valid,
  input  logic [WIN*PIX_W-1:0] win_pixels,
  output logic                 res_valid,
  output logic [PIX_W-1:0]     res_pixel
);

  localparam int KEY_W = PIX_W + 1;
  localparam int CNT_W = $clog2(WIN + 1);
  localparam int CTR   = WIN / 2;

  // stage 1: input capture
  logic                 v1;
  logic [WIN*PIX_W-1:0] win1;

  // stage 2: classified keys
  logic                 v2;
  logic [WIN*KEY_W-1:0] keys2;
  logic [CNT_W-1:0]     clean2, high2;
  logic [PIX_W-1:0]     ctr2;
  logic                 cnoise2;

  // stage 3: sorted keys and fallback mean
  logic                 v3;
  logic [WIN*KEY_W-1:0] sorted3;
  logic [CNT_W-1:0]     clean3;
  logic [PIX_W-1:0]     mean3;
  logic [PIX_W-1:0]     ctr3;
  logic                 cnoise3;

  logic [WIN*KEY_W-1:0] keys_c, sorted_c;
  logic [CNT_W-1:0]     clean_c, high_c;
  logic [PIX_W-1:0]     mean_c;
  logic [PIX_W-1:0]     ctr1;
  logic [CNT_W-1:0]     med_idx;
  logic [PIX_W-1:0]     med_val;
  logic [PIX_W-1:0]     pick;

  snp_classify #(.PIX_W(PIX_W), .WIN(WIN)) u_cls (
    .pixels    (win1),
    .keys      (keys_c),
    .clean_cnt (clean_c),
    .high_cnt  (high_c)
  );

  snp_sort_net #(.KEY_W(KEY_W), .N(WIN)) u_sort (
    .keys_in  (keys2),
    .keys_out (sorted_c)
  );

  snp_fallback_mean #(.PIX_W(PIX_W), .WIN(WIN)) u_mean (
    .high_cnt (high2),
    .mean     (mean_c)
  );

  assign ctr1 = win1[CTR*PIX_W +: PIX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      v1 <= win_valid;
      v2 <= v1;
      v3 <= v2;
      res_valid <= v3;
    end
  end

  // datapath registers carry no reset
  always_ff @(posedge clk) begin
    win1    <= win_pixels;
    keys2   <= keys_c;
    clean2  <= clean_c;
    high2   <= high_c;
    ctr2    <= ctr1;
    cnoise2 <= (classify_px(16'(ctr1), PIX_W) != PX_CLEAN);
    sorted3 <= sorted_c;
    clean3  <= clean2;
    mean3   <= mean_c;
    ctr3    <= ctr2;
    cnoise3 <= cnoise2;
    res_pixel <= pick;
  end

  // lower median of the clean keys, which occupy the low end after sorting
  assign med_idx = (clean3 - CNT_W'(1)) >> 1;
  assign med_val = sorted3[med_idx*KEY_W +: PIX_W];

  always_comb begin
    if (!cnoise3)            pick = ctr3;
    else if (clean3 == '0)   pick = mean3;
    else                     pick = med_val;
  end

endmodule

// File: rtl/snp_restorer_chk.sv
module snp_restorer_chk #(
  parameter int PIX_W = 8,
  parameter int WIN   = 9
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 win_valid,
  input logic [WIN*PIX_W-1:0] win_pixels,
  input logic                 res_valid,
  input logic [PIX_W-1:0]     res_pixel
);

  localparam int CTR = WIN / 2;
  localparam int DLY = 4;
  localparam logic [PIX_W-1:0] TOP = {PIX_W{1'b1}};

  logic [DLY-1:0]   cv;
  logic [DLY-1:0]   cnoise;
  logic [DLY-1:0]   anyclean;
  logic [DLY-1:0]   allzero;
  logic [PIX_W-1:0] cc [DLY];

  logic [PIX_W-1:0] ctr_in;
  logic             ac_in, az_in;

  assign ctr_in = win_pixels[CTR*PIX_W +: PIX_W];

  always_comb begin
    ac_in = 1'b0;
    az_in = 1'b1;
    for (int i = 0; i < WIN; i++) begin
      if (win_pixels[i*PIX_W +: PIX_W] != '0 && win_pixels[i*PIX_W +: PIX_W] != TOP)
        ac_in = 1'b1;
      if (win_pixels[i*PIX_W +: PIX_W] != '0)
        az_in = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cv <= '0;
    else     cv <= {cv[DLY-2:0], win_valid};
    cnoise   <= {cnoise[DLY-2:0], (ctr_in == '0 || ctr_in == TOP)};
    anyclean <= {anyclean[DLY-2:0], ac_in};
    allzero  <= {allzero[DLY-2:0], az_in};
    cc[0] <= ctr_in;
    for (int k = 1; k < DLY; k++) cc[k] <= cc[k-1];
  end

  a_r6_reset_quiet: assert property (@(posedge clk) rst |=> !res_valid);

  a_r7_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    res_valid == cv[DLY-1]);

  a_r2_clean_passthrough: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !cnoise[DLY-1]) |-> res_pixel == cc[DLY-1]);

  a_r3_median_is_clean: assert property (@(posedge clk) disable iff (rst)
    (res_valid && cnoise[DLY-1] && anyclean[DLY-1]) |-> (res_pixel != '0 && res_pixel != TOP));

  a_r5_black_mean: assert property (@(posedge clk) disable iff (rst)
    (res_valid && allzero[DLY-1]) |-> res_pixel == '0);

endmodule

bind snp_restorer snp_restorer_chk #(.PIX_W(PIX_W), .WIN(WIN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .win_valid  (win_valid),
  .win_pixels (win_pixels),
  .res_valid  (res_valid),
  .res_pixel  (res_pixel)
);

// File: tb/snp_restorer_test.sv
module snp_restorer_test;

  localparam int PIX_W = 8;
  localparam int WIN   = 9;
  localparam int NV    = 14;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 win_valid = 1'b0;
  logic [WIN*PIX_W-1:0] win_pixels = '0;
  logic                 res_valid;
  logic [PIX_W-1:0]     res_pixel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  snp_restorer #(.PIX_W(PIX_W), .WIN(WIN)) uut (
    .clk (clk), .rst (rst), .win_valid (win_valid),
    .win_pixels (win_pixels), .res_valid (res_valid), .res_pixel (res_pixel)
  );

  // {expected, p8, p7, p6, p5, p4(centre), p3, p2, p1, p0}  (R8 layout)
  localparam logic [79:0] VEC [NV] = '{
    {8'd100, 8'd9,   8'd8,   8'd7,   8'd6,   8'd100, 8'd4,   8'd3,   8'd2,   8'd1  }, // R2
    {8'd40,  8'd80,  8'd70,  8'd60,  8'd50,  8'd0,   8'd40,  8'd30,  8'd20,  8'd10 }, // R4 n=8
    {8'd12,  8'd255, 8'd200, 8'd0,   8'd7,   8'd255, 8'd255, 8'd12,  8'd255, 8'd0  }, // R3 n=3
    {8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0  }, // R5 c=0
    {8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255}, // R5 c=9
    {8'd142, 8'd0,   8'd255, 8'd0,   8'd255, 8'd255, 8'd0,   8'd255, 8'd0,   8'd255}, // R5 c=5
    {8'd57,  8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd255, 8'd255}, // R5 c=2
    {8'd227, 8'd255, 8'd255, 8'd255, 8'd255, 8'd0,   8'd255, 8'd255, 8'd255, 8'd255}, // R5 c=8
    {8'd1,   8'd255, 8'd0,   8'd0,   8'd0,   8'd255, 8'd0,   8'd0,   8'd1,   8'd0  }, // R3 n=1
    {8'd1,   8'd0,   8'd0,   8'd0,   8'd0,   8'd1,   8'd0,   8'd0,   8'd0,   8'd0  }, // R1 value 1 clean
    {8'd254, 8'd255, 8'd255, 8'd255, 8'd255, 8'd254, 8'd255, 8'd255, 8'd255, 8'd255}, // R1 value 254 clean
    {8'd4,   8'd8,   8'd7,   8'd6,   8'd5,   8'd255, 8'd4,   8'd3,   8'd2,   8'd1  }, // R4 n=8
    {8'd30,  8'd0,   8'd255, 8'd0,   8'd90,  8'd0,   8'd255, 8'd0,   8'd30,  8'd255}, // R4 n=2
    {8'd113, 8'd255, 8'd255, 8'd255, 8'd255, 8'd0,   8'd0,   8'd0,   8'd0,   8'd0  }  // R5 c=4
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int k);
    case (k)
      0:          return "R2";
      1, 11, 12:  return "R4";
      2, 8:       return "R3";
      9, 10:      return "R1";
      default:    return "R5";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset idle", int'(res_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    // one window at a time: result after the fourth edge (R7)
    for (int k = 0; k < NV; k++) begin
      win_pixels = VEC[k][71:0];
      win_valid  = 1'b1;
      @(negedge clk);
      win_valid  = 1'b0;
      win_pixels = '0;
      repeat (2) @(negedge clk);
      chk("R7 not early", int'(res_valid), 0);
      @(negedge clk);
      chk("R7 valid", int'(res_valid), 1);
      chk(tag_of(k), int'(res_pixel), int'(VEC[k][79:72]));
      @(negedge clk);
      chk("R7 single pulse", int'(res_valid), 0);
    end

    // back-to-back stream: accept and deliver in the same cycle (R7)
    for (int k = 0; k < NV + 4; k++) begin
      if (k >= 4) begin
        chk("R7 stream valid", int'(res_valid), 1);
        chk(tag_of(k - 4), int'(res_pixel), int'(VEC[k-4][79:72]));
      end
      if (k < NV) begin
        win_pixels = VEC[k][71:0];
        win_valid  = 1'b1;
      end else begin
        win_valid  = 1'b0;
      end
      @(negedge clk);
    end
    chk("R7 stream drained", int'(res_valid), 0);

    // reset with windows in flight (R6)
    win_pixels = VEC[0][71:0];
    win_valid  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    win_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk("R6 flush", int'(res_valid), 0);
      @(negedge clk);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule